// File: doc/BRIEF.md
# NAND Page ECC Status and Correction Unit

This unit runs alongside a NAND page read that is split into equal ECC blocks. A running byte counter shows how far the read has got. When a check is requested, the counter is shifted down by the block size to find the block that has just been passed. The unit then compares the computed parity with the stored parity for that block and sorts the block into one of three classes: clean, correctable or uncorrectable. It records the class in a sticky status word and returns a signed result code one cycle later. The parity algorithm is outside the unit; parity, error byte location and syndrome all arrive as inputs.

For a correctable block the unit keeps the word offset of the error and the 16-bit syndrome. It then corrects the page data in a local buffer by XORing the syndrome into the 32-bit word that the error location points at. The host loads and reads that buffer through a plain write port and a plain read port. A page-start pulse clears all recorded state before each new page.

Top module: `ecc_page_corrector`

## Requirements
- R1: After reset, and one cycle after `page_start` is high, `err_status` is zero and `res_valid` is low. The held word offsets and syndromes are also cleared.
- R2: On a check, the affected block is `(addr_cnt >> log2(BLK_BYTES)) - 1`. Uncorrectable bits sit at `err_status[b]` and correctable bits at `err_status[16+b]`. All other status bits stay zero.
- R3: If the shifted counter value is zero or larger than `NUM_BLKS`, the result code is 2'b11 (-1). No status bit changes and no buffer word changes.
- R4: If the computed parity equals the stored parity and the block has no earlier status bits, the result code is 2'b00 (0).
- R5: The block is correctable when the parities differ, the syndrome is nonzero and the error location is below `BLK_BYTES`. The unit then sets `err_status[16+b]`, returns 2'b01 (+1), and holds `loc[log2(BLK_BYTES)-1:2]` and the syndrome for block b.
- R6: The block is uncorrectable when the parities differ in any other way. The unit then sets `err_status[b]` and returns 2'b11. Status bits stay set until the next page start.
- R7: If a block's uncorrectable bit is set, or becomes set by the current check, the code is 2'b11. A stored correctable bit with no uncorrectable bit gives 2'b01, even when the parities now match. A check whose block already has its uncorrectable bit set makes no buffer change.
- R8: A correctable check XORs the zero-extended syndrome into buffer word `b*BLK_BYTES/4 + (loc >> 2)`. This word is visible on the read port in the next cycle.
- R9: `res_valid` is a single-cycle pulse in the cycle after a sampled `chk_req`. `res_code` is valid in that same cycle.
- R10: When `page_start` and `chk_req` are high together, the clear wins. No result is produced and no buffer word changes.
- R11: A host write stores `host_wr_data` at `host_wr_addr`. `host_rd_data` shows the word at `host_rd_addr` without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| page_start | input | 1 | Clears status and held values for a new page |
| chk_req | input | 1 | Request to evaluate the block just passed |
| addr_cnt | input | CNT_W | Running byte address counter of the page read |
| calc_par | input | PAR_W | Parity computed over the block |
| stored_par | input | PAR_W | Parity read from the spare area |
| err_loc | input | LOC_W | Byte location of the error inside the block |
| err_syn | input | SYN_W | Syndrome bits to flip |
| host_wr_en | input | 1 | Buffer write strobe |
| host_wr_addr | input | BUF_AW | Buffer write word address |
| host_wr_data | input | 32 | Buffer write data |
| host_rd_addr | input | BUF_AW | Buffer read word address |
| host_rd_data | output | 32 | Buffer read data |
| res_valid | output | 1 | Result pulse |
| res_code | output | 2 | 00 clean, 01 corrected, 11 failure |
| err_status | output | 32 | Uncorrectable bits low, correctable bits from bit 16 |
| hold_sel | input | IDX_W | Block whose held values are shown |
| hold_word_off | output | log2(BLK_BYTES)-2 | Held error word offset |
| hold_syn | output | SYN_W | Held syndrome |

## Verification
The bench builds the unit with 256-byte blocks, eight blocks per page and a 12-bit counter. With these values the counter can land in the zero bucket, on the last legal block and one bucket past the page. The buffer has 512 words, so a correction in the last block hits the final buffer word. A vector table walks clean, correctable, uncorrectable, out-of-range and repeat checks of the same block. Directed tests then cover page start racing with a check, and plain host buffer access.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

   typedef enum logic [1:0] {
      RES_CLEAN = 2'b00,
      RES_FIXED = 2'b01,
      RES_FAIL  = 2'b11
   } res_code_e;

   typedef enum logic [1:0] {
      CL_CLEAN = 2'b00,
      CL_FIX   = 2'b01,
      CL_BAD   = 2'b10
   } blk_class_e;

   function automatic bit blk_size_ok(int unsigned bytes);
      return (bytes == 128) || (bytes == 256) || (bytes == 512) || (bytes == 1024);
   endfunction

endpackage

// File: rtl/ecc_blk_index.sv
module ecc_blk_index #(
   parameter int CNT_W    = 12,
   parameter int SHIFT    = 8,
   parameter int NUM_BLKS = 8,
   parameter int IDX_W    = 3
) (
   input  logic [CNT_W-1:0] cnt,
   output logic [IDX_W-1:0] idx,
   output logic             legal
);
   logic [CNT_W-1:0] bucket;
   logic [CNT_W-1:0] below;

   // Bucket k>0 means block k-1 has been passed by at least one access.
   assign bucket = cnt >> SHIFT;
   assign below  = bucket - CNT_W'(1);
   assign legal  = (bucket != '0) && (bucket <= CNT_W'(NUM_BLKS));
   assign idx    = below[IDX_W-1:0];
endmodule

// File: rtl/ecc_blk_classify.sv
module ecc_blk_classify
   import ecc_pkg::*;
#(
   parameter int PAR_W = 24,
   parameter int LOC_W = 11,
   parameter int SYN_W = 16,
   parameter int SHIFT = 8
) (
   input  logic [PAR_W-1:0] calc,
   input  logic [PAR_W-1:0] stored,
   input  logic [LOC_W-1:0] loc,
   input  logic [SYN_W-1:0] syn,
   output blk_class_e       cls
);
   logic in_range;

   generate
      if (LOC_W > SHIFT) begin : g_range_chk
         assign in_range = (loc[LOC_W-1:SHIFT] == '0);
      end else begin : g_range_free
         assign in_range = 1'b1;
      end
   endgenerate

   always_comb begin
      if (calc == stored)
         cls = CL_CLEAN;
      else if ((syn != '0) && in_range)
         cls = CL_FIX;
      else
         cls = CL_BAD;
   end
endmodule

// File: rtl/ecc_fix_buffer.sv
module ecc_fix_buffer #(
   parameter int WORDS = 512,
   parameter int AW    = 9,
   parameter int SYN_W = 16
) (
   input  logic             clk,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [31:0]      wr_data,
   input  logic             fix_en,
   input  logic [AW-1:0]    fix_addr,
   input  logic [SYN_W-1:0] fix_mask,
   input  logic [AW-1:0]    rd_addr,
   output logic [31:0]      rd_data
);
   logic [31:0] mem [WORDS];
   logic [31:0] mask_w;

   assign mask_w  = 32'(fix_mask);
   assign rd_data = mem[rd_addr];

   // A correction owns the single write port; a host write in that cycle is dropped.
   always_ff @(posedge clk) begin
      if (fix_en)
         mem[fix_addr] <= mem[fix_addr] ^ mask_w;
      else if (wr_en)
         mem[wr_addr] <= wr_data;
   end

   a_r8_fix_flips_word: assert property (@(posedge clk)
      (fix_en && !(wr_en && wr_addr == fix_addr) && rd_addr == fix_addr)
      |=> ($past(rd_rd_chk) ^ rd_data) == $past(mask_w))
      else $error("R8 correction did not flip the selected word");

   logic [31:0] rd_rd_chk;
   assign rd_rd_chk = mem[fix_addr];
endmodule

// File: rtl/ecc_page_corrector.sv
module ecc_page_corrector
   import ecc_pkg::*;
#(
   parameter int BLK_BYTES = 256,
   parameter int NUM_BLKS  = 8,
   parameter int CNT_W     = 12,
   parameter int PAR_W     = 24,
   parameter int SYN_W     = 16,
   parameter int LOC_W     = 11,
   localparam int SHIFT     = $clog2(BLK_BYTES),
   localparam int BLK_WORDS = BLK_BYTES / 4,
   localparam int BUF_WORDS = NUM_BLKS * BLK_WORDS,
   localparam int BUF_AW    = $clog2(BUF_WORDS),
   localparam int IDX_W     = (NUM_BLKS > 1) ? $clog2(NUM_BLKS) : 1,
   localparam int WOFF_W    = SHIFT - 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              page_start,
   input  logic              chk_req,
   input  logic [CNT_W-1:0]  addr_cnt,
   input  logic [PAR_W-1:0]  calc_par,
   input  logic [PAR_W-1:0]  stored_par,
   input  logic [LOC_W-1:0]  err_loc,
   input  logic [SYN_W-1:0]  err_syn,
   input  logic              host_wr_en,
   input  logic [BUF_AW-1:0] host_wr_addr,
   input  logic [31:0]       host_wr_data,
   input  logic [BUF_AW-1:0] host_rd_addr,
   output logic [31:0]       host_rd_data,
   output logic              res_valid,
   output logic [1:0]        res_code,
   output logic [31:0]       err_status,
   input  logic [IDX_W-1:0]  hold_sel,
   output logic [WOFF_W-1:0] hold_word_off,
   output logic [SYN_W-1:0]  hold_syn
);
   // ---------------- elaboration checks ----------------
   generate
      if (!blk_size_ok(BLK_BYTES)) begin : g_bad_blk
         $error("BLK_BYTES must be 128, 256, 512 or 1024");
      end
      if (NUM_BLKS < 1 || NUM_BLKS > 16) begin : g_bad_num
         $error("NUM_BLKS must lie in 1..16 to fit both status halves");
      end
      if (CNT_W < SHIFT + IDX_W + 1) begin : g_bad_cnt
         $error("CNT_W too narrow to pass the last block boundary");
      end
      if (LOC_W < SHIFT) begin : g_bad_loc
         $error("LOC_W must cover a whole block");
      end
   endgenerate

   // ---------------- block index and class ----------------
   logic [IDX_W-1:0] idx;
   logic             legal;
   blk_class_e       cls;

   ecc_blk_index #(
      .CNT_W(CNT_W), .SHIFT(SHIFT), .NUM_BLKS(NUM_BLKS), .IDX_W(IDX_W)
   ) u_index (
      .cnt(addr_cnt), .idx(idx), .legal(legal)
   );

   ecc_blk_classify #(
      .PAR_W(PAR_W), .LOC_W(LOC_W), .SYN_W(SYN_W), .SHIFT(SHIFT)
   ) u_class (
      .calc(calc_par), .stored(stored_par), .loc(err_loc), .syn(err_syn), .cls(cls)
   );

   // ---------------- per-block sticky state ----------------
   logic              go;
   logic [NUM_BLKS-1:0] u_q;
   logic [NUM_BLKS-1:0] c_q;
   logic [WOFF_W-1:0] off_q [NUM_BLKS];
   logic [SYN_W-1:0]  syn_q [NUM_BLKS];

   assign go = chk_req && !page_start && legal;

   generate
      for (genvar g = 0; g < NUM_BLKS; g++) begin : g_blk
         logic hit;
         assign hit = go && (idx == IDX_W'(g));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               u_q[g]   <= 1'b0;
               c_q[g]   <= 1'b0;
               off_q[g] <= '0;
               syn_q[g] <= '0;
            end else if (page_start) begin
               u_q[g]   <= 1'b0;
               c_q[g]   <= 1'b0;
               off_q[g] <= '0;
               syn_q[g] <= '0;
            end else if (hit) begin
               if (cls == CL_BAD)
                  u_q[g] <= 1'b1;
               if (cls == CL_FIX) begin
                  c_q[g]   <= 1'b1;
                  off_q[g] <= err_loc[SHIFT-1:2];
                  syn_q[g] <= err_syn;
               end
            end
         end
      end
   endgenerate

   // ---------------- result code ----------------
   logic      u_now, c_now;
   res_code_e code_d, code_q;
   logic      valid_q;

   assign u_now = u_q[idx] | (cls == CL_BAD);
   assign c_now = c_q[idx] | (cls == CL_FIX);

   always_comb begin
      if (!legal || u_now)
         code_d = RES_FAIL;
      else if (c_now)
         code_d = RES_FIXED;
      else
         code_d = RES_CLEAN;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         code_q  <= RES_CLEAN;
      end else begin
         valid_q <= chk_req && !page_start;
         if (chk_req && !page_start)
            code_q <= code_d;
      end
   end

   assign res_valid = valid_q;
   assign res_code  = code_q;

   always_comb begin
      err_status = '0;
      err_status[NUM_BLKS-1:0]  = u_q;
      err_status[16 +: NUM_BLKS] = c_q;
   end

   always_comb begin
      if (32'(hold_sel) < NUM_BLKS) begin
         hold_word_off = off_q[hold_sel];
         hold_syn      = syn_q[hold_sel];
      end else begin
         hold_word_off = '0;
         hold_syn      = '0;
      end
   end

   // ---------------- correction buffer ----------------
   logic              fix_en;
   logic [BUF_AW-1:0] fix_addr;

   assign fix_en   = go && (cls == CL_FIX) && !u_q[idx];
   assign fix_addr = BUF_AW'({idx, err_loc[SHIFT-1:2]});

   ecc_fix_buffer #(
      .WORDS(BUF_WORDS), .AW(BUF_AW), .SYN_W(SYN_W)
   ) u_buf (
      .clk(clk),
      .wr_en(host_wr_en), .wr_addr(host_wr_addr), .wr_data(host_wr_data),
      .fix_en(fix_en), .fix_addr(fix_addr), .fix_mask(err_syn),
      .rd_addr(host_rd_addr), .rd_data(host_rd_data)
   );

   // ---------------- assertions ----------------
   a_r1_clear_on_page: assert property (@(posedge clk) disable iff (!rst_n)
      page_start |=> (err_status == 32'd0 && !res_valid))
      else $error("R1 page start did not clear state");

   a_r3_illegal_fails: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_req && !page_start && !legal) |=> (res_valid && res_code == 2'b11))
      else $error("R3 out-of-range bucket did not fail");

   a_r3_illegal_no_status: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_req && !page_start && !legal) |=> $stable(err_status))
      else $error("R3 out-of-range bucket changed status");

   a_r6_sticky_bits: assert property (@(posedge clk) disable iff (!rst_n)
      !page_start |=> (($past(err_status) & ~err_status) == 32'd0))
      else $error("R6 a status bit dropped without page start");

   a_r7_uncorr_priority: assert property (@(posedge clk) disable iff (!rst_n)
      (go && u_q[idx]) |=> (res_code == 2'b11))
      else $error("R7 recorded uncorrectable block did not fail");

   a_r9_result_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $past(chk_req))
      else $error("R9 result without a request");

   a_r10_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (page_start && chk_req) |=> !res_valid)
      else $error("R10 result produced during page start");
endmodule

// File: tb/tb_ecc_page_corrector.sv
module tb_ecc_page_corrector;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 9;
   localparam int NW = 512;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        page_start = 1'b0;
   logic        chk_req = 1'b0;
   logic [11:0] addr_cnt = '0;
   logic [23:0] calc_par = '0;
   logic [23:0] stored_par = '0;
   logic [10:0] err_loc = '0;
   logic [15:0] err_syn = '0;
   logic        host_wr_en = 1'b0;
   logic [8:0]  host_wr_addr = '0;
   logic [31:0] host_wr_data = '0;
   logic [8:0]  host_rd_addr = '0;
   logic [31:0] host_rd_data;
   logic        res_valid;
   logic [1:0]  res_code;
   logic [31:0] err_status;
   logic [2:0]  hold_sel = '0;
   logic [5:0]  hold_word_off;
   logic [15:0] hold_syn;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ecc_page_corrector dut (
      .clk(clk), .rst_n(rst_n), .page_start(page_start), .chk_req(chk_req),
      .addr_cnt(addr_cnt), .calc_par(calc_par), .stored_par(stored_par),
      .err_loc(err_loc), .err_syn(err_syn),
      .host_wr_en(host_wr_en), .host_wr_addr(host_wr_addr), .host_wr_data(host_wr_data),
      .host_rd_addr(host_rd_addr), .host_rd_data(host_rd_data),
      .res_valid(res_valid), .res_code(res_code), .err_status(err_status),
      .hold_sel(hold_sel), .hold_word_off(hold_word_off), .hold_syn(hold_syn)
   );

   // Vector table: counter, parities, location, syndrome, expected code.
   localparam logic [11:0] V_CNT  [NV] = '{12'h104, 12'h210, 12'h301, 12'h400, 12'h0FF,
                                           12'h8FF, 12'h900, 12'h2FF, 12'h350};
   localparam logic [23:0] V_CALC [NV] = '{24'h123456, 24'hAAAAAA, 24'h111111, 24'h333333, 24'h000000,
                                           24'h000001, 24'h000000, 24'h444444, 24'h000001};
   localparam logic [23:0] V_STOR [NV] = '{24'h123456, 24'hAAAAAB, 24'h222222, 24'h333330, 24'h000001,
                                           24'h000002, 24'h000001, 24'h444444, 24'h000002};
   localparam logic [10:0] V_LOC  [NV] = '{11'h000, 11'h00A, 11'h004, 11'h100, 11'h008,
                                           11'h0FF, 11'h000, 11'h000, 11'h010};
   localparam logic [15:0] V_SYN  [NV] = '{16'h0000, 16'h00F0, 16'h0000, 16'h0005, 16'h0001,
                                           16'hFFFF, 16'h0001, 16'h0000, 16'h1234};
   localparam logic [1:0]  V_CODE [NV] = '{2'b00, 2'b01, 2'b11, 2'b11, 2'b11,
                                           2'b01, 2'b11, 2'b01, 2'b11};

   logic [31:0] mbuf [NW];
   logic [7:0]  mu = '0;
   logic [7:0]  mc = '0;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] model_status();
      return {8'h00, mc, 8'h00, mu};
   endfunction

   // Reference update from the requirement text (R2, R3, R5, R6, R7, R8).
   task automatic model_apply(input int k);
      int bucket, b;
      bit mism, fix, bad;
      bucket = int'(V_CNT[k]) >> 8;
      if (bucket == 0 || bucket > 8) return;
      b = bucket - 1;
      mism = (V_CALC[k] != V_STOR[k]);
      fix  = mism && (V_SYN[k] != 16'h0) && (V_LOC[k] < 11'd256);
      bad  = mism && !fix;
      if (fix && !mu[b])
         mbuf[b*64 + int'(V_LOC[k] >> 2)] ^= {16'h0, V_SYN[k]};
      if (bad) mu[b] = 1'b1;
      if (fix) mc[b] = 1'b1;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 reset status", err_status, 32'h0);
      check("R1 reset valid", {31'h0, res_valid}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R11: load buffer through host port
      for (int i = 0; i < NW; i++) begin
         host_wr_en = 1'b1;
         host_wr_addr = 9'(i);
         host_wr_data = 32'hC0DE0000 ^ 32'(i * 7);
         mbuf[i] = 32'hC0DE0000 ^ 32'(i * 7);
         @(negedge clk);
      end
      host_wr_en = 1'b0;
      host_rd_addr = 9'd300;
      #1;
      check("R11 host readback", host_rd_data, mbuf[300]);

      page_start = 1'b1;
      @(negedge clk);
      page_start = 1'b0;

      // Vector walk: R2..R9
      for (int k = 0; k < NV; k++) begin
         addr_cnt = V_CNT[k];
         calc_par = V_CALC[k];
         stored_par = V_STOR[k];
         err_loc = V_LOC[k];
         err_syn = V_SYN[k];
         chk_req = 1'b1;
         model_apply(k);
         @(negedge clk);
         chk_req = 1'b0;
         check($sformatf("R9 valid v%0d", k), {31'h0, res_valid}, 32'h1);
         check($sformatf("R4/R5/R6/R7/R3 code v%0d", k), {30'h0, res_code}, {30'h0, V_CODE[k]});
         check($sformatf("R2 status v%0d", k), err_status, model_status());
         @(negedge clk);
         check($sformatf("R9 pulse end v%0d", k), {31'h0, res_valid}, 32'h0);
         if (k == 1) begin
            hold_sel = 3'd1;
            #1;
            check("R5 held offset blk1", {26'h0, hold_word_off}, 32'd2);
            check("R5 held syndrome blk1", {16'h0, hold_syn}, 32'h00F0);
         end
      end

      // R8: whole buffer against model (corrections at words 66 and 511 only)
      for (int i = 0; i < NW; i++) begin
         host_rd_addr = 9'(i);
         #1;
         check($sformatf("R8 buffer word %0d", i), host_rd_data, mbuf[i]);
      end
      hold_sel = 3'd2;
      #1;
      check("R5 held syndrome blk2", {16'h0, hold_syn}, 32'h1234);
      check("R7 blocked fix word 132", mbuf[132], 32'hC0DE0000 ^ 32'(132 * 7));

      // R1: page start clears
      @(negedge clk);
      page_start = 1'b1;
      @(negedge clk);
      page_start = 1'b0;
      check("R1 page start status", err_status, 32'h0);
      check("R1 page start syndrome", {16'h0, hold_syn}, 32'h0);

      // R10: page start together with a correctable check
      addr_cnt = 12'h210; calc_par = 24'h1; stored_par = 24'h2;
      err_loc = 11'h00C; err_syn = 16'h0F0F;
      page_start = 1'b1; chk_req = 1'b1;
      @(negedge clk);
      page_start = 1'b0; chk_req = 1'b0;
      check("R10 no result", {31'h0, res_valid}, 32'h0);
      check("R10 status clear", err_status, 32'h0);
      host_rd_addr = 9'd67;
      #1;
      check("R10 buffer untouched", host_rd_data, mbuf[67]);

      // R4: clean block in fresh page, then R11 write/read
      addr_cnt = 12'h5A0; calc_par = 24'h77; stored_par = 24'h77;
      chk_req = 1'b1;
      @(negedge clk);
      chk_req = 1'b0;
      check("R4 clean fresh", {30'h0, res_code}, 32'h0);
      host_wr_en = 1'b1; host_wr_addr = 9'd5; host_wr_data = 32'hDEADBEEF;
      @(negedge clk);
      host_wr_en = 1'b0; host_rd_addr = 9'd5;
      #1;
      check("R11 write read", host_rd_data, 32'hDEADBEEF);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule